// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block brings a DDR2 memory from power-on to a usable state. After reset it holds the clock enable low and drives NOPs for a fixed power-up wait. It then steps through the JEDEC mode-register programming order:

- precharge-all, then the three extended register loads (EMR2, EMR3, EMR1);
- a mode register load that resets the DLL, then a second precharge-all;
- two auto-refreshes, then the mode register load again without the DLL reset;
- the off-chip-driver calibration default and exit pair on EMR1.

Each wait between commands is taken from one of three timing inputs, chosen by the kind of command just issued. Those inputs are the load-to-load gap, the precharge period and the refresh cycle time.

Once the sequence ends, `init_done` rises. A simple write port then lets software push single raw commands onto the memory bus. The block checks each write and rejects it, raising `cmd_err`, in two cases: while initialization is still running, and when it is a READ issued before the DLL lock time has passed since the DLL reset. The last command that reached the bus, from the sequence or from the write port, can always be read back.

Top module: `ddr2_init_seq`

## Requirements
- R1: After power-up, exactly eleven commands are issued in this order, with this bank address: precharge (0), EMR2 load (2), EMR3 load (3), EMR1 load (1), MR load (0), precharge (0), refresh (0), refresh (0), MR load (0), EMR1 load (1), EMR1 load (1). The command codes {cs_n,ras_n,cas_n,we_n} are: load 0000, precharge 0010, refresh 0001, NOP 0111.
- R2: From reset release, `cke` stays low and the bus carries NOP for exactly PWRUP_CYC cycles. The first precharge appears in the first cycle in which `cke` is high, and `cke` never falls again.
- R3: The first MR load carries address 0xB52 and the second carries 0xA52. These values encode burst length 4 in A2..A0 = 010, CAS latency 5 in A6..A4 = 101 and write recovery 6 in A11..A9 = 101. A8 (DLL reset) is set only in the first load. EMR2 and EMR3 loads carry address 0.
- R4: The first and last EMR1 loads carry 0x046, which sets reduced drive strength on A1 and 50-ohm termination on A2 and A6. The middle EMR1 load carries 0x3C6: the same bits plus A9..A7 = 111 (calibration default).
- R5: Every precharge drives A10 high, so that it acts on all banks.
- R6: The issue-to-issue distance after each sequence command is set by the command just issued: `cfg_trp` cycles after a precharge, `cfg_trfc` after a refresh and `cfg_tmrd` after a register load. The cycles in between carry NOP.
- R7: `init_done` rises exactly `cfg_tmrd` cycles after the final EMR1 load and stays high until reset.
- R8: An accepted write of `reg_wdata` appears on the bus in the cycle after the write, for one cycle. The word layout is [22:19] = {cs_n,ras_n,cas_n,we_n}, [18:16] = bank, [15:0] = address.
- R9: `reg_rdata` holds the last command word issued. Its reset value is the NOP word 0x380000, and after initialization it reads the final EMR1 load 0x010046.
- R10: A write issued while `init_done` is low is not issued, and `cmd_err` is high in the following cycle.
- R11: A READ word (command code 0101) written fewer than `cfg_tdllk` cycles after the DLL-reset MR load is rejected: the bus stays NOP and `cmd_err` is set. After that time, a READ is accepted.
- R12: An accepted write clears `cmd_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory-side clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_tmrd | input | TW | Cycles between a register load and the next command |
| cfg_trp | input | TW | Cycles after a precharge |
| cfg_trfc | input | TW | Cycles after a refresh |
| cfg_tdllk | input | TW | DLL lock time before a READ may be issued |
| reg_wr | input | 1 | Command write strobe |
| reg_wdata | input | 4+BW+AW | Command word to issue |
| reg_rdata | output | 4+BW+AW | Last command word issued |
| cke | output | 1 | Clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BW | Bank address |
| addr | output | AW | Address bus |
| init_done | output | 1 | Initialization finished |
| cmd_err | output | 1 | Last command write was rejected |

## Verification
The hardest state to reach is the short window after `init_done` in which the DLL lock time has not yet passed. Only there is a READ rejected while other commands are accepted. With the default timings, lock completes about thirty cycles after `init_done`. The bench therefore writes a READ right after `init_done` and a second one forty cycles later, and expects a rejection and then an issue. A second run uses tight timings, including a one-cycle register gap that skips the wait state. A write during the power-up wait covers the rejection while the sequence is still running.

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq #(
  parameter int AW = 16,
  parameter int BW = 3,
  parameter int TW = 8,
  parameter int PWRUP_CYC = 100,
  parameter logic [2:0] MR_BL = 3'b010,
  parameter logic [2:0] MR_CL = 3'b101,
  parameter logic [2:0] MR_WR = 3'b101,
  parameter logic [15:0] EMR1_CFG = 16'h0046
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TW-1:0]     cfg_tmrd,
  input  logic [TW-1:0]     cfg_trp,
  input  logic [TW-1:0]     cfg_trfc,
  input  logic [TW-1:0]     cfg_tdllk,
  input  logic              reg_wr,
  input  logic [3+BW+AW:0]  reg_wdata,
  output logic [3+BW+AW:0]  reg_rdata,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BW-1:0]     ba,
  output logic [AW-1:0]     addr,
  output logic              init_done,
  output logic              cmd_err
);
  localparam int CW    = 4 + BW + AW;
  localparam int PW    = $clog2(PWRUP_CYC + 1);
  localparam int CNT_W = (TW > PW) ? TW : PW;

  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_PRE = 4'b0010;
  localparam logic [3:0] C_REF = 4'b0001;
  localparam logic [3:0] C_MRS = 4'b0000;
  localparam logic [3:0] C_RD  = 4'b0101;

  localparam logic [3:0] LAST_STEP = 4'd10;
  localparam logic [3:0] DLL_STEP  = 4'd4;

  localparam logic [AW-1:0] MR_W     = AW'({MR_WR, 1'b0, 1'b0, MR_CL, 1'b0, MR_BL});
  localparam logic [AW-1:0] MR_DLL   = MR_W | AW'(12'h100);
  localparam logic [AW-1:0] PRE_A    = AW'(11'h400);
  localparam logic [AW-1:0] EMR1_W   = AW'(EMR1_CFG);
  localparam logic [AW-1:0] EMR1_OCD = AW'(EMR1_CFG) | AW'(10'h380);
  localparam logic [CW-1:0] NOP_WORD = {C_NOP, {BW{1'b0}}, {AW{1'b0}}};

  typedef enum logic [1:0] {PH_PWR, PH_CMD, PH_WAIT, PH_DONE} phase_t;

  phase_t           phase;
  logic [3:0]       step;
  logic [CNT_W-1:0] cnt;
  logic [TW-1:0]    gap;
  logic [TW-1:0]    dll_cnt;
  logic             dll_armed;
  logic             man_vld;
  logic [CW-1:0]    man_word;
  logic [CW-1:0]    cur_word;
  logic             accept;
  logic             dll_ok;
  logic             is_rd;

  function automatic logic [CW-1:0] step_word(input logic [3:0] s);
    case (s)
      4'd0, 4'd5: return {C_PRE, BW'(0), PRE_A};
      4'd1:       return {C_MRS, BW'(2), {AW{1'b0}}};
      4'd2:       return {C_MRS, BW'(3), {AW{1'b0}}};
      4'd3:       return {C_MRS, BW'(1), EMR1_W};
      4'd4:       return {C_MRS, BW'(0), MR_DLL};
      4'd6, 4'd7: return {C_REF, BW'(0), {AW{1'b0}}};
      4'd8:       return {C_MRS, BW'(0), MR_W};
      4'd9:       return {C_MRS, BW'(1), EMR1_OCD};
      4'd10:      return {C_MRS, BW'(1), EMR1_W};
      default:    return NOP_WORD;
    endcase
  endfunction

  always_comb begin
    case (step)
      4'd0, 4'd5: gap = cfg_trp;
      4'd6, 4'd7: gap = cfg_trfc;
      default:    gap = cfg_tmrd;
    endcase
  end

  assign init_done = (phase == PH_DONE);
  assign cke       = (phase != PH_PWR);
  assign dll_ok    = dll_armed && (dll_cnt == '0);
  assign is_rd     = (reg_wdata[CW-1 -: 4] == C_RD);
  assign accept    = reg_wr && init_done && !(is_rd && !dll_ok);

  always_comb begin
    if (phase == PH_CMD)                 cur_word = step_word(step);
    else if (init_done && man_vld)       cur_word = man_word;
    else                                 cur_word = NOP_WORD;
  end

  assign {cs_n, ras_n, cas_n, we_n} = cur_word[CW-1 -: 4];
  assign ba   = cur_word[AW +: BW];
  assign addr = cur_word[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_PWR;
      step  <= '0;
      cnt   <= CNT_W'(PWRUP_CYC - 1);
    end else begin
      case (phase)
        PH_PWR: begin
          if (cnt == '0) phase <= PH_CMD;
          else           cnt   <= cnt - 1'b1;
        end
        PH_CMD: begin
          if (gap > TW'(1)) begin
            phase <= PH_WAIT;
            cnt   <= CNT_W'(gap) - CNT_W'(2);
          end else if (step == LAST_STEP) begin
            phase <= PH_DONE;
          end else begin
            step <= step + 1'b1;
          end
        end
        PH_WAIT: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else if (step == LAST_STEP) begin
            phase <= PH_DONE;
          end else begin
            phase <= PH_CMD;
            step  <= step + 1'b1;
          end
        end
        default: phase <= PH_DONE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dll_armed <= 1'b0;
      dll_cnt   <= '0;
    end else if (phase == PH_CMD && step == DLL_STEP) begin
      dll_armed <= 1'b1;
      dll_cnt   <= (cfg_tdllk == '0) ? '0 : cfg_tdllk - 1'b1;
    end else if (dll_cnt != '0) begin
      dll_cnt <= dll_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      man_vld   <= 1'b0;
      man_word  <= NOP_WORD;
      cmd_err   <= 1'b0;
      reg_rdata <= NOP_WORD;
    end else begin
      man_vld <= accept;
      if (accept) man_word <= reg_wdata;
      if (reg_wr) cmd_err <= !accept;
      if (phase == PH_CMD || (init_done && man_vld)) reg_rdata <= cur_word;
    end
  end
endmodule

module ddr2_init_seq_chk #(
  parameter int AW = 16,
  parameter int BW = 3,
  parameter int TW = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cke,
  input logic             cs_n,
  input logic             ras_n,
  input logic             cas_n,
  input logic             we_n,
  input logic [BW-1:0]    ba,
  input logic [AW-1:0]    addr,
  input logic             init_done,
  input logic             cmd_err,
  input logic             reg_wr,
  input logic [3+BW+AW:0] reg_wdata,
  input logic [TW-1:0]    cfg_tmrd,
  input logic [TW-1:0]    cfg_trp,
  input logic [TW-1:0]    cfg_trfc
);
  logic [9:0]    since;
  logic [TW-1:0] req;
  logic          seen;
  logic          issued;
  logic [2:0]    rcw;

  assign rcw    = {ras_n, cas_n, we_n};
  assign issued = !cs_n && (rcw != 3'b111);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since <= '0;
      req   <= '0;
      seen  <= 1'b0;
    end else if (issued) begin
      since <= 10'd1;
      seen  <= 1'b1;
      req   <= (rcw == 3'b010) ? cfg_trp : (rcw == 3'b001) ? cfg_trfc : cfg_tmrd;
    end else if (since != 10'h3ff) begin
      since <= since + 1'b1;
    end
  end

  a_r2_cke_low_nop: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> (!init_done && !issued));
  a_r2_cke_stays_high: assert property (@(posedge clk) disable iff (!rst_n)
    cke |=> cke);
  a_r5_precharge_all: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && rcw == 3'b010) |-> addr[10]);
  a_r6_min_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (issued && seen && !init_done) |-> (int'(since) >= int'(req)));
  a_r7_done_after_tmrd: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done) |-> (int'(since) == int'(cfg_tmrd)));
  a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);
  a_r8_manual_issue: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(reg_wr && init_done) && !cmd_err) |-> ({cs_n, ras_n, cas_n, we_n, ba, addr} == $past(reg_wdata)));
  a_r10_reject_in_init: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !init_done) |=> cmd_err);
endmodule

bind ddr2_init_seq ddr2_init_seq_chk #(.AW(AW), .BW(BW), .TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
  .we_n(we_n), .ba(ba), .addr(addr), .init_done(init_done), .cmd_err(cmd_err),
  .reg_wr(reg_wr), .reg_wdata(reg_wdata), .cfg_tmrd(cfg_tmrd), .cfg_trp(cfg_trp),
  .cfg_trfc(cfg_trfc)
);

// File: tb/test_ddr2_init_seq.sv
`timescale 1ns/1ps
module test_ddr2_init_seq;
  localparam int PWR = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cfg_tmrd = 8'd2, cfg_trp = 8'd5, cfg_trfc = 8'd78, cfg_tdllk = 8'd200;
  logic        reg_wr = 1'b0;
  logic [22:0] reg_wdata = '0;
  logic [22:0] reg_rdata;
  logic        cke, cs_n, ras_n, cas_n, we_n, init_done, cmd_err;
  logic [2:0]  ba;
  logic [15:0] addr;

  int n_chk = 0, n_fail = 0;
  int rec_n, cyc, cke_low, done_cyc;
  logic [3:0]  rec_code [32];
  logic [2:0]  rec_ba   [32];
  logic [15:0] rec_addr [32];
  int          rec_cyc  [32];

  ddr2_init_seq #(.PWRUP_CYC(PWR)) i_ddr2_init_seq (
    .clk(clk), .rst_n(rst_n), .cfg_tmrd(cfg_tmrd), .cfg_trp(cfg_trp),
    .cfg_trfc(cfg_trfc), .cfg_tdllk(cfg_tdllk), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cke(cke), .cs_n(cs_n),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
    .init_done(init_done), .cmd_err(cmd_err)
  );

  always #2 clk = ~clk;

  always @(negedge clk) begin
    if (!rst_n) begin
      rec_n = 0; cyc = 0; cke_low = 0; done_cyc = -1;
    end else begin
      cyc++;
      if (!cke) cke_low++;
      if (!cs_n && {ras_n, cas_n, we_n} != 3'b111 && rec_n < 32) begin
        rec_code[rec_n] = {cs_n, ras_n, cas_n, we_n};
        rec_ba[rec_n]   = ba;
        rec_addr[rec_n] = addr;
        rec_cyc[rec_n]  = cyc;
        rec_n++;
      end
      if (init_done && done_cyc < 0) done_cyc = cyc;
    end
  end

  function automatic logic [22:0] wd(input logic [3:0] c, input logic [2:0] b, input logic [15:0] a);
    return {c, b, a};
  endfunction

  function automatic logic [22:0] bus();
    return {cs_n, ras_n, cas_n, we_n, ba, addr};
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  task automatic do_reset(input int tmrd, input int trp, input int trfc, input int tdllk);
    rst_n = 1'b0; reg_wr = 1'b0;
    cfg_tmrd = 8'(tmrd); cfg_trp = 8'(trp); cfg_trfc = 8'(trfc); cfg_tdllk = 8'(tdllk);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R2", "cke in reset", 32'(cke), 0);
    chk("R2", "bus in reset", 32'(bus()), 32'(wd(4'b0111, 3'd0, 16'h0)));
    chk("R7", "done in reset", 32'(init_done), 0);
    chk("R9", "rdata reset", 32'(reg_rdata), 32'h380000);
    @(posedge clk); #1 rst_n = 1'b1;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 3000 && !init_done; i++) @(negedge clk);
    #1;
  endtask

  function automatic logic [3:0] exp_code(input int i);
    case (i)
      0, 5:    return 4'b0010;
      6, 7:    return 4'b0001;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic logic [2:0] exp_ba(input int i);
    case (i)
      1: return 3'd2; 2: return 3'd3; 3, 9, 10: return 3'd1;
      default: return 3'd0;
    endcase
  endfunction

  task automatic check_seq(input int tmrd, input int trp, input int trfc);
    chk("R2", "cke low cycles", 32'(cke_low), 32'(PWR));
    chk("R2", "first command cycle", 32'(rec_cyc[0]), 32'(PWR + 1));
    chk("R1", "command count", 32'(rec_n), 11);
    for (int i = 0; i < 11; i++) begin
      chk("R1", $sformatf("code step %0d", i), 32'(rec_code[i]), 32'(exp_code(i)));
      chk("R1", $sformatf("bank step %0d", i), 32'(rec_ba[i]), 32'(exp_ba(i)));
    end
    chk("R5", "pre1 A10", 32'(rec_addr[0][10]), 1);
    chk("R5", "pre2 A10", 32'(rec_addr[5][10]), 1);
    chk("R3", "EMR2 addr", 32'(rec_addr[1]), 0);
    chk("R3", "EMR3 addr", 32'(rec_addr[2]), 0);
    chk("R3", "MR with DLL reset", 32'(rec_addr[4]), 32'h0B52);
    chk("R3", "MR without DLL reset", 32'(rec_addr[8]), 32'h0A52);
    chk("R4", "EMR1 first", 32'(rec_addr[3]), 32'h0046);
    chk("R4", "EMR1 OCD default", 32'(rec_addr[9]), 32'h03C6);
    chk("R4", "EMR1 OCD exit", 32'(rec_addr[10]), 32'h0046);
    for (int i = 0; i < 10; i++) begin
      int g;
      g = (i == 0 || i == 5) ? trp : (i == 6 || i == 7) ? trfc : tmrd;
      chk("R6", $sformatf("gap after step %0d", i), 32'(rec_cyc[i+1] - rec_cyc[i]), 32'(g));
    end
    chk("R7", "done delay", 32'(done_cyc - rec_cyc[10]), 32'(tmrd));
    chk("R9", "rdata after init", 32'(reg_rdata), 32'h010046);
  endtask

  task automatic write_cmd(input logic [22:0] w);
    @(negedge clk);
    reg_wr = 1'b1; reg_wdata = w;
    @(negedge clk);
    reg_wr = 1'b0;
    #1;
  endtask

  task automatic t_init_default();
    do_reset(2, 5, 78, 200);
    repeat (3) @(negedge clk);
    write_cmd(wd(4'b0011, 3'd1, 16'h0001));
    chk("R10", "err on early write", 32'(cmd_err), 1);
    chk("R10", "no command issued", 32'(rec_n), 0);
    wait_done();
    chk("R7", "done reached", 32'(init_done), 1);
    check_seq(2, 5, 78);
    repeat (4) @(negedge clk);
    chk("R7", "done held", 32'(init_done), 1);
  endtask

  task automatic t_read_guard();
    logic [22:0] rd;
    rd = wd(4'b0101, 3'd2, 16'h0040);
    write_cmd(rd);
    chk("R11", "early read bus NOP", 32'(bus()), 32'(wd(4'b0111, 3'd0, 16'h0)));
    chk("R11", "early read err", 32'(cmd_err), 1);
    repeat (40) @(negedge clk);
    write_cmd(rd);
    chk("R11", "late read on bus", 32'(bus()), 32'(rd));
    chk("R12", "err cleared", 32'(cmd_err), 0);
    @(negedge clk); #1;
    chk("R8", "single cycle issue", 32'(bus()), 32'(wd(4'b0111, 3'd0, 16'h0)));
    chk("R9", "rdata read", 32'(reg_rdata), 32'(rd));
  endtask

  task automatic t_manual_act();
    logic [22:0] act;
    act = wd(4'b0011, 3'd5, 16'h1234);
    write_cmd(act);
    chk("R8", "activate on bus", 32'(bus()), 32'(act));
    @(negedge clk); #1;
    chk("R9", "rdata activate", 32'(reg_rdata), 32'(act));
  endtask

  task automatic t_fast_timing();
    logic [22:0] rd;
    do_reset(1, 3, 10, 4);
    wait_done();
    check_seq(1, 3, 10);
    rd = wd(4'b0101, 3'd0, 16'h0008);
    write_cmd(rd);
    chk("R11", "read after short lock", 32'(bus()), 32'(rd));
    chk("R12", "no err", 32'(cmd_err), 0);
  endtask

  initial begin
    t_init_default();
    t_read_guard();
    t_manual_act();
    t_fast_timing();
    finish_run();
  end
endmodule